// File: doc/BRIEF.md
# Approximate Multiply-Accumulate with Learned Correction Seeding

This block is the arithmetic core of a windowed image filter. Each output pixel is the sum of 49 products, one per tap of a 7x7 window. Each product is an 8-bit pixel times a 9-bit coefficient. The multiplier can drop a chosen number of its least-significant partial-product columns, which trades accuracy for switching activity. Products pass through one register stage into a 20-bit accumulator that wraps modulo 2^20. The top 8 bits of the final sum, which is the sum divided by 4096, form the filtered pixel.

The accumulator does not have to start from zero. On the first tap of a window it can be seeded with one of four values:
- the previous window's sum,
- a zero or a fixed static constant,
- the correction value just produced by the update subtractor,
- the value held in the correction register.

The update subtractor takes a captured window sum and subtracts the correction value that was held when that sum was captured. If a low-accuracy window is captured while the correction is zero, the register learns that raw sum. If an accurate window is then captured against that raw sum, the register learns the difference between the two. If a corrected window is captured against the correction it used, the register recovers the uncorrected sum. All control comes from an external sequencer that drives per-cycle strobes. Line buffering is done elsewhere.

Top module: `approx_mac`

## Requirements
- R1: After reset, outValid is 0, winSum is 0, the correction register is 0 and the subtractor operands are 0.
- R2: A product equals the sum of a[i]&b[j]·2^(i+j) over the pixel bits i and coefficient bits j with i+j ≥ truncCols. With truncCols = 0 the product is exact, and with truncCols ≥ 16 it is 0.
- R3: A window ends on the 49th tap, counted as a cycle with inValid = 1. The product of a tap sampled at edge k is added at edge k+1. So outValid is high for exactly one cycle, after the edge that follows the edge sampling the 49th tap. While it is high, winSum holds the seed plus all 49 products modulo 2^20, and pixOut is winSum[19:12].
- R4: seedSel = 2'b00 on a window's first tap continues from the previous accumulator value.
- R5: seedSel = 2'b10 seeds with 0 when seedZero = 1, or with staticCorr when seedZero = 0.
- R6: seedSel = 2'b11 seeds with the correction register value, sign-extended to 20 bits.
- R7: seedSel = 2'b01 seeds with the subtractor output. That output is the captured sum minus the captured correction, taken modulo 2^20.
- R8: The subtractor operands load winSum and the correction register at every edge where updHold = 0. While updHold = 1 they hold, so the subtractor output stays fixed across later windows.
- R9: corrKeep = 0 clears the correction register at the next edge, whatever corrLoad is.
- R10: With corrKeep = 1, corrLoad = 1 loads the subtractor output into the correction register, and corrLoad = 0 leaves the register unchanged.
- R11: seedSel and seedZero are used only from the window's first tap. Their values on the other taps have no effect.
- R12: Cycles with inValid = 0 inside a window leave the accumulator and the tap count unchanged, whatever pixel, coef or seedSel carry during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a tap carrying a valid pixel and coefficient |
| pixel | input | 8 | Unsigned pixel operand |
| coef | input | 9 | Unsigned coefficient operand |
| truncCols | input | 5 | Number of low product columns to drop |
| seedSel | input | 2 | Seed source, sampled on the first tap of a window |
| seedZero | input | 1 | Chooses zero (1) or the static constant (0) for seed 2'b10 |
| staticCorr | input | 20 | Static correction constant, held stable by the sequencer |
| updHold | input | 1 | 1 freezes the subtractor operands |
| corrKeep | input | 1 | 0 clears the correction register |
| corrLoad | input | 1 | Enables a correction register load |
| outValid | output | 1 | One-cycle pulse when a window sum is complete |
| pixOut | output | 8 | Filtered pixel, winSum[19:12] |
| winSum | output | 20 | Accumulator value |

## Verification
The hardest state to reach is a fresh-value seed (2'b01) that reflects a capture made several windows earlier. To get there, a sum must be captured and the correction reloaded. Then a whole window must run with the operands frozen, and only after that can the next window be seeded. The stimulus runs directed learning sequences in this order: raw load, difference load, corrected reload, chained window, frozen-operand seed, clear racing a load, and capture without load. Random windows follow, with random truncation, seed source and update actions, and idle gaps are sometimes placed inside a window.

// File: rtl/approx_mac_pkg.sv
package approx_mac_pkg;

  typedef enum logic [1:0] {
    SEED_CHAIN  = 2'b00,
    SEED_FRESH  = 2'b01,
    SEED_CONST  = 2'b10,
    SEED_STORED = 2'b11
  } seedSel_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic     tapIn;      // operand sampling enable (current cycle)
    logic     tapValid;   // registered product is a valid tap
    logic     tapFirst;   // registered product opens a window
    logic     tapLast;    // registered product closes a window
    seedSel_e seedSel;    // seed source for the opening tap
    logic     seedZero;   // constant choice for SEED_CONST
    logic     opCapture;  // subtractor operands load this edge
    logic     corrClear;  // correction register clears this edge
    logic     corrLoad;   // correction register loads this edge
  } macStrobe_t;

endpackage

// File: rtl/approx_mac_mult.sv
module approx_mac_mult #(
  parameter int A_W     = 8,
  parameter int B_W     = 9,
  parameter int TRUNC_W = 5
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  input  logic [TRUNC_W-1:0] truncCols,
  output logic [A_W+B_W-1:0] prod
);
  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] keepMask;
  logic [P_W-1:0] rows [A_W];

  // Shifting past the width leaves zero, so the mask clears every column
  assign keepMask = ~((P_W'(1) << truncCols) - P_W'(1));

  for (genvar i = 0; i < A_W; i++) begin : g_row
    logic [P_W-1:0] rowRaw;
    assign rowRaw  = a[i] ? (P_W'(b) << i) : '0;
    assign rows[i] = rowRaw & keepMask;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < A_W; i++) prod = prod + rows[i];
  end

endmodule

// File: rtl/approx_mac_ctrl.sv
module approx_mac_ctrl import approx_mac_pkg::*; #(
  parameter int TAPS = 49
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] seedSel,
  input  logic       seedZero,
  input  logic       updHold,
  input  logic       corrKeep,
  input  logic       corrLoad,
  output macStrobe_t strb
);
  localparam int CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic [CNT_W-1:0] tapCnt;
  logic             atFirst, atLast;
  logic             validQ, firstQ, lastQ, zeroQ;
  seedSel_e         selQ;

  assign atFirst = (tapCnt == '0);
  assign atLast  = (tapCnt == CNT_W'(TAPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tapCnt <= '0;
      validQ <= 1'b0;
      firstQ <= 1'b0;
      lastQ  <= 1'b0;
      selQ   <= SEED_CHAIN;
      zeroQ  <= 1'b0;
    end else begin
      validQ <= inValid;
      firstQ <= inValid && atFirst;
      lastQ  <= inValid && atLast;
      if (inValid) begin
        tapCnt <= atLast ? '0 : tapCnt + CNT_W'(1);
        if (atFirst) begin
          selQ  <= seedSel_e'(seedSel);
          zeroQ <= seedZero;
        end
      end
    end
  end

  always_comb begin
    strb.tapIn     = inValid;
    strb.tapValid  = validQ;
    strb.tapFirst  = firstQ;
    strb.tapLast   = lastQ;
    strb.seedSel   = selQ;
    strb.seedZero  = zeroQ;
    strb.opCapture = !updHold;
    strb.corrClear = !corrKeep;
    strb.corrLoad  = corrLoad;
  end

endmodule

// File: rtl/approx_mac_dp.sv
module approx_mac_dp import approx_mac_pkg::*; #(
  parameter int A_W     = 8,
  parameter int B_W     = 9,
  parameter int TRUNC_W = 5,
  parameter int ACC_W   = 20,
  parameter int CORR_W  = 20,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  macStrobe_t         strb,
  input  logic [A_W-1:0]     pixel,
  input  logic [B_W-1:0]     coef,
  input  logic [TRUNC_W-1:0] truncCols,
  input  logic [ACC_W-1:0]   staticCorr,
  output logic               outValid,
  output logic [PIX_W-1:0]   pixOut,
  output logic [ACC_W-1:0]   winSum
);
  localparam int P_W   = A_W + B_W;
  localparam int SHIFT = ACC_W - PIX_W;

  logic [P_W-1:0]           prodComb, prodReg;
  logic [ACC_W-1:0]         acc, seedVal, feedVal;
  logic signed [CORR_W-1:0] corrReg, opCorr, freshCorr;
  logic [ACC_W-1:0]         opAcc, corrExt, opCorrExt, freshExt;

  approx_mac_mult #(.A_W(A_W), .B_W(B_W), .TRUNC_W(TRUNC_W)) u_mult (
    .a(pixel), .b(coef), .truncCols(truncCols), .prod(prodComb)
  );

  // Stage 1: product register
  always_ff @(posedge clk) begin
    if (rst)             prodReg <= '0;
    else if (strb.tapIn) prodReg <= prodComb;
  end

  // Correction values are signed and widened to the accumulator
  assign corrExt   = ACC_W'(corrReg);
  assign opCorrExt = ACC_W'(opCorr);
  assign freshCorr = CORR_W'(opAcc - opCorrExt);
  assign freshExt  = ACC_W'(freshCorr);

  always_comb begin
    unique case (strb.seedSel)
      SEED_CHAIN:  seedVal = acc;
      SEED_FRESH:  seedVal = freshExt;
      SEED_CONST:  seedVal = strb.seedZero ? '0 : staticCorr;
      SEED_STORED: seedVal = corrExt;
      default:     seedVal = acc;
    endcase
    feedVal = strb.tapFirst ? seedVal : acc;
  end

  // Stage 2: accumulator with seeded feedback
  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.tapValid && strb.tapLast;
      if (strb.tapValid) acc <= feedVal + ACC_W'(prodReg);
    end
  end

  // Update subtractor operands, frozen while the hold is asserted
  always_ff @(posedge clk) begin
    if (rst) begin
      opAcc  <= '0;
      opCorr <= '0;
    end else if (strb.opCapture) begin
      opAcc  <= acc;
      opCorr <= corrReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.corrClear) corrReg <= '0;
    else if (strb.corrLoad)    corrReg <= freshCorr;
  end

  assign winSum = acc;
  assign pixOut = acc[SHIFT +: PIX_W];

endmodule

// File: rtl/approx_mac.sv
module approx_mac import approx_mac_pkg::*; #(
  parameter int A_W     = 8,
  parameter int B_W     = 9,
  parameter int TRUNC_W = 5,
  parameter int ACC_W   = 20,
  parameter int CORR_W  = 20,
  parameter int PIX_W   = 8,
  parameter int KSIZE   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [A_W-1:0]     pixel,
  input  logic [B_W-1:0]     coef,
  input  logic [TRUNC_W-1:0] truncCols,
  input  logic [1:0]         seedSel,
  input  logic               seedZero,
  input  logic [ACC_W-1:0]   staticCorr,
  input  logic               updHold,
  input  logic               corrKeep,
  input  logic               corrLoad,
  output logic               outValid,
  output logic [PIX_W-1:0]   pixOut,
  output logic [ACC_W-1:0]   winSum
);
  localparam int TAPS = KSIZE * KSIZE;

  macStrobe_t strb;

  approx_mac_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .seedSel(seedSel),
    .seedZero(seedZero), .updHold(updHold), .corrKeep(corrKeep),
    .corrLoad(corrLoad), .strb(strb)
  );

  approx_mac_dp #(
    .A_W(A_W), .B_W(B_W), .TRUNC_W(TRUNC_W), .ACC_W(ACC_W),
    .CORR_W(CORR_W), .PIX_W(PIX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .pixel(pixel), .coef(coef),
    .truncCols(truncCols), .staticCorr(staticCorr), .outValid(outValid),
    .pixOut(pixOut), .winSum(winSum)
  );

endmodule

// File: rtl/approx_mac_chk.sv
module approx_mac_chk import approx_mac_pkg::*; #(
  parameter int TAPS  = 49,
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst,
  input macStrobe_t       strb,
  input logic             outValid,
  input logic [ACC_W-1:0] winSum
);
  localparam int CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic [CNT_W-1:0] tapSeen;

  always_ff @(posedge clk) begin
    if (rst) tapSeen <= '0;
    else if (strb.tapValid)
      tapSeen <= (tapSeen == CNT_W'(TAPS - 1)) ? '0 : tapSeen + CNT_W'(1);
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  a_r3_valid_after_last: assert property (@(posedge clk) disable iff (rst)
    (strb.tapValid && strb.tapLast) |=> outValid);

  a_r3_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(strb.tapValid && strb.tapLast));

  a_r12_idle_keeps_sum: assert property (@(posedge clk) disable iff (rst)
    !strb.tapValid |=> $stable(winSum));

  a_r12_last_on_count: assert property (@(posedge clk) disable iff (rst)
    (strb.tapValid && strb.tapLast) |-> (tapSeen == CNT_W'(TAPS - 1)));

  a_r11_first_on_count: assert property (@(posedge clk) disable iff (rst)
    (strb.tapValid && strb.tapFirst) |-> (tapSeen == '0));

endmodule

bind approx_mac approx_mac_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .outValid(outValid), .winSum(winSum)
);

// File: tb/approx_mac_bench.sv
`timescale 1ns/1ps
module approx_mac_bench;
  localparam int TAPS = 49;
  localparam logic [19:0] STATIC_C = 20'h0_3A5C;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [7:0]  pixel;
  logic [8:0]  coef;
  logic [4:0]  truncCols;
  logic [1:0]  seedSel;
  logic        seedZero;
  logic [19:0] staticCorr;
  logic        updHold, corrKeep, corrLoad;
  logic        outValid;
  logic [7:0]  pixOut;
  logic [19:0] winSum;

  int nChk = 0;
  int nFail = 0;
  logic [19:0] mAcc, mCorr, mOpA, mOpC;

  always #2.5 clk = ~clk;

  approx_mac u_approx_mac (
    .clk(clk), .rst(rst), .inValid(inValid), .pixel(pixel), .coef(coef),
    .truncCols(truncCols), .seedSel(seedSel), .seedZero(seedZero),
    .staticCorr(staticCorr), .updHold(updHold), .corrKeep(corrKeep),
    .corrLoad(corrLoad), .outValid(outValid), .pixOut(pixOut), .winSum(winSum)
  );

  function automatic logic [19:0] truncProd(input logic [7:0] a, input logic [8:0] b,
                                            input int k);
    logic [19:0] r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 9; j++)
        if (a[i] && b[j] && (i + j) >= k) r = r + (20'd1 << (i + j));
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic runWindow(input string tag, input int sel, input bit zero,
                           input int trunc, input bit zeroData, input bit gaps,
                           input bit cap, input bit load, input bit clr);
    logic [19:0] sum;
    case (sel)
      0: sum = mAcc;
      1: sum = mOpA - mOpC;
      2: sum = zero ? 20'd0 : STATIC_C;
      default: sum = mCorr;
    endcase
    for (int k = 0; k < TAPS; k++) begin
      if (gaps && (k % 7) == 3) begin
        @(negedge clk);
        inValid = 1'b0; pixel = 8'($urandom); coef = 9'($urandom);
        seedSel = 2'($urandom); seedZero = 1'($urandom);
      end
      @(negedge clk);
      inValid   = 1'b1;
      pixel     = zeroData ? 8'd0 : 8'($urandom);
      coef      = zeroData ? 9'd0 : 9'($urandom);
      truncCols = 5'(trunc);
      seedSel   = (k == 0) ? 2'(sel) : 2'($urandom);
      seedZero  = (k == 0) ? zero : 1'($urandom);
      sum       = sum + truncProd(pixel, coef, trunc);
    end
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R3 outValid before sum complete", 32'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, {"R3 outValid at window end ", tag}, 32'(outValid), 1);
    check(winSum == sum, {"winSum ", tag}, 32'(winSum), 32'(sum));
    check(pixOut == sum[19:12], "R3 pixOut bits", 32'(pixOut), 32'(sum[19:12]));
    mAcc = sum;
    if (cap) updHold = 1'b0;
    @(negedge clk);
    updHold = 1'b1;
    check(outValid == 1'b0, "R3 outValid one cycle", 32'(outValid), 0);
    if (cap) begin mOpA = sum; mOpC = mCorr; end
    if (load || clr) begin
      corrLoad = load; corrKeep = !clr;
      @(negedge clk);
      corrLoad = 1'b0; corrKeep = 1'b1;
      mCorr = clr ? 20'd0 : (mOpA - mOpC);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; inValid = 1'b0; pixel = '0; coef = '0; truncCols = '0;
    seedSel = '0; seedZero = 1'b0; staticCorr = STATIC_C;
    updHold = 1'b1; corrKeep = 1'b1; corrLoad = 1'b0;
    mAcc = '0; mCorr = '0; mOpA = '0; mOpC = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", 32'(outValid), 0);
    check(winSum == 20'd0, "R1 reset winSum", 32'(winSum), 0);
    check(pixOut == 8'd0, "R1 reset pixOut", 32'(pixOut), 0);

    runWindow("R1 R6 stored seed after reset", 3, 0, 0, 1, 0, 0, 0, 0);
    runWindow("R1 R7 fresh seed after reset", 1, 0, 0, 1, 0, 0, 0, 0);
    runWindow("R2 R5 exact zero seed", 2, 1, 0, 0, 0, 1, 1, 0);
    runWindow("R2 R5 static seed trunc4", 2, 0, 4, 0, 0, 1, 1, 0);
    runWindow("R7 fresh difference seed", 1, 0, 8, 0, 0, 0, 0, 0);
    runWindow("R6 R12 stored seed with gaps", 3, 0, 8, 0, 1, 1, 1, 0);
    runWindow("R4 R11 chained window", 0, 0, 6, 0, 0, 0, 0, 0);
    runWindow("R8 fresh seed with frozen operands", 1, 0, 10, 0, 0, 0, 0, 0);
    runWindow("R9 clear during load", 2, 1, 3, 0, 0, 1, 1, 1);
    runWindow("R9 stored after clear", 3, 0, 3, 0, 0, 1, 0, 0);
    runWindow("R10 stored after capture only", 3, 0, 17, 0, 0, 0, 0, 0);
    runWindow("R2 full truncation", 2, 0, 16, 0, 0, 0, 0, 0);

    for (int w = 0; w < 14; w++) begin
      int r;
      r = int'($urandom_range(0, 3));
      runWindow("R11 R12 random window", r, 1'($urandom), int'($urandom_range(0, 17)),
                0, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0));
    end
    finishRun();
  end

endmodule